// File: doc/BRIEF.md
# Flash page program-verify controller

This block runs the write-and-check loop that programs one page of a flash array. Software or a loader fills a page buffer through a byte-wide load port, picks the target page and an attempt limit, and pulses `start`. The controller raises the write-enable mode and streams a working copy of the page into the array. It then asks an external pulse sequencer for a programming pulse and reads every byte back in verify mode. From the readback it rebuilds the working copy, so that only bits that are still unprogrammed are driven again.

While the attempt count is small, each verify pass is followed by a short extra pulse on the bits that have just reached 0. The loop repeats until the page reads back correctly or the attempt limit is used up. The block then drops the write-enable mode, waits the required settling time and reports success or failure. Erasing and the analog side of programming stay outside the block. The pulse sequencer and the array are reached only through the ports below.

States: `ST_IDLE`, `ST_SWE_ON` (enable settle), `ST_PROG_WR` (stream working copy), `ST_PROG_PULSE`, `ST_PV_SET` (verify settle), `ST_V_DUMMY`, `ST_V_WAIT`, `ST_V_READ`, `ST_V_CHECK`, `ST_PV_CLR` (verify exit settle), `ST_ADD_WR` (stream extra-pulse data), `ST_ADD_PULSE`, `ST_DECIDE`, `ST_SWE_OFF` (exit settle). The transitions are:
- `ST_IDLE` to `ST_SWE_ON` on start.
- `ST_SWE_ON` to `ST_PROG_WR` after the enable settle time.
- `ST_PROG_WR` to `ST_PROG_PULSE` after the last byte.
- `ST_PROG_PULSE` to `ST_PV_SET` on pulse done.
- `ST_PV_SET` to `ST_V_DUMMY` after the verify settle time.
- `ST_V_DUMMY` to `ST_V_WAIT` to `ST_V_READ` to `ST_V_CHECK`, for each byte.
- `ST_V_CHECK` back to `ST_V_DUMMY` for the next byte, or on to `ST_PV_CLR` after the last byte.
- `ST_PV_CLR` to `ST_ADD_WR` when the attempt is 6 or lower, otherwise to `ST_DECIDE`.
- `ST_ADD_WR` to `ST_ADD_PULSE` to `ST_DECIDE`.
- `ST_DECIDE` to `ST_PROG_WR` to retry, or to `ST_SWE_OFF` to finish.
- `ST_SWE_OFF` to `ST_IDLE` after the exit settle time.

Top module: `fpv_page_ctrl`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `fail`, `swe_en`, `pv_en`, `fl_we`, `fl_re` and `pulse_req` are all 0, and they stay quiet while idle.
- R2: While idle, a load with `ld_en` high writes `ld_data` into both the program buffer and the working buffer at byte `ld_idx`. A load while busy is ignored.
- R3: `swe_en` is high for exactly `T_X` cycles before the first array write of a run. `swe_en` is low for exactly `T_THETA` busy cycles before `done` or `fail` rises, on both outcomes.
- R4: A program pass writes all `PAGE_BYTES` bytes of the working buffer. It writes them in ascending index order to address `{page_sel, index}`, one per cycle with `fl_we` high, and never asserts `fl_we` and `fl_re` together. One pulse request follows the pass.
- R5: The `pulse_width` code is 0 (short) for program attempts 1 to 6, 1 (long) for attempts 7 and above, and 2 (extra) for the extra pulse. `pulse_req` stays high until `pulse_done`.
- R6: Verify mode holds `pv_en` high. For each byte in ascending order, the block writes 0xFF to the byte's address, waits `T_EPS` cycles and then asserts `fl_re`. It compares the data returned on the next cycle with the program buffer.
- R7: After verify, each working byte becomes `prog | ~read`. A byte that verified is therefore written as 0xFF on later passes, and a byte that did not is written again with its program value (when the array is still erased).
- R8: After each verify pass of attempts 1 to 6, the block writes `prog | read` for every byte and requests one extra pulse. After attempt 7 and later it writes no such data.
- R9: `pv_en` is low during every pulse request, and the block waits `T_ETA` cycles after leaving verify mode.
- R10: When every byte of a pass matches, the run ends with `done`=1 and `fail`=0 after exactly as many program attempts as the array needed. `done` and `fail` are never both 1, and they hold until the next start.
- R11: When a pass still has a mismatch and the attempt count equals the limit, the run ends with `fail`=1 and `done`=0 after exactly that many attempts. A `max_attempts` value of 0 selects a limit of 1000.
- R12: A `start` pulse while busy has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Page-buffer load strobe (idle only) |
| ld_idx | input | IDX_W | Byte index of the load |
| ld_data | input | 8 | Byte to load |
| start | input | 1 | Begin a programming run |
| page_sel | input | PAGE_W | Target page, captured at start |
| max_attempts | input | AT_W | Attempt limit, 0 selects 1000 |
| fl_addr | output | PAGE_W+IDX_W | Array byte address |
| fl_wdata | output | 8 | Array write data |
| fl_we | output | 1 | Array write strobe |
| fl_re | output | 1 | Array read strobe, data expected next cycle |
| fl_rdata | input | 8 | Array read data |
| pulse_req | output | 1 | Programming pulse request |
| pulse_width | output | 2 | Pulse width code: 0 short, 1 long, 2 extra |
| pulse_done | input | 1 | Pulse sequencer completion |
| swe_en | output | 1 | Array write-enable mode |
| pv_en | output | 1 | Program-verify mode |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run ended with the page verified |
| fail | output | 1 | Run ended at the attempt limit |

## Verification
The hardest behaviour to reach from the ports is a long history of attempts. Such a history crosses the switch from short to long pulses, stops the extra pulses, and ends exactly at or one step past the attempt limit. The bench models the array so that every byte needs its own number of program pulses before its zero bits take hold. The page data and these per-byte pulse counts are drawn from a seeded generator, with one byte forced to the largest count, so the number of attempts a run needs is known in advance. Directed pages then place that count at 6, 7, 8, the limit and one past it. A mid-run load and start test that the running sequence ignores them.

// File: rtl/fpv_pkg.sv
package fpv_pkg;

    typedef enum logic [1:0] {
        PW_Z1 = 2'd0,
        PW_Z2 = 2'd1,
        PW_Z3 = 2'd2
    } pw_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SWE_ON,
        ST_PROG_WR,
        ST_PROG_PULSE,
        ST_PV_SET,
        ST_V_DUMMY,
        ST_V_WAIT,
        ST_V_READ,
        ST_V_CHECK,
        ST_PV_CLR,
        ST_ADD_WR,
        ST_ADD_PULSE,
        ST_DECIDE,
        ST_SWE_OFF
    } st_e;

endpackage

// File: rtl/fpv_dwell_timer.sv
module fpv_dwell_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] count
);
    // Cycles spent in the current state; saturates.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (restart)
            count <= '0;
        else if (count != '1)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/fpv_page_buf.sv
module fpv_page_buf #(
    parameter int BYTES = 128,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [7:0]       ld_data,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [7:0]       upd_rep,
    input  logic [7:0]       upd_add,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       prog_q,
    output logic [7:0]       rep_q,
    output logic [7:0]       add_q
);
    logic [7:0] prog_mem [BYTES];
    logic [7:0] rep_mem  [BYTES];
    logic [7:0] add_mem  [BYTES];

    always_ff @(posedge clk) begin
        if (ld_en) prog_mem[ld_idx] <= ld_data;
    end

    always_ff @(posedge clk) begin
        if (ld_en)
            rep_mem[ld_idx] <= ld_data;
        else if (upd_en)
            rep_mem[upd_idx] <= upd_rep;
    end

    always_ff @(posedge clk) begin
        if (upd_en) add_mem[upd_idx] <= upd_add;
    end

    assign prog_q = prog_mem[rd_idx];
    assign rep_q  = rep_mem[rd_idx];
    assign add_q  = add_mem[rd_idx];
endmodule

// File: rtl/fpv_page_ctrl.sv
module fpv_page_ctrl
    import fpv_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int PAGE_W     = 4,
    parameter int AT_W       = 10,
    parameter int Z1_LIMIT   = 6,
    parameter int DEF_MAX    = 1000,
    parameter int T_X        = 4,
    parameter int T_THETA    = 3,
    parameter int T_GAMMA    = 2,
    parameter int T_EPS      = 2,
    parameter int T_ETA      = 2,
    parameter int IDX_W      = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_en,
    input  logic [IDX_W-1:0]        ld_idx,
    input  logic [7:0]              ld_data,
    input  logic                    start,
    input  logic [PAGE_W-1:0]       page_sel,
    input  logic [AT_W-1:0]         max_attempts,
    output logic [PAGE_W+IDX_W-1:0] fl_addr,
    output logic [7:0]              fl_wdata,
    output logic                    fl_we,
    output logic                    fl_re,
    input  logic [7:0]              fl_rdata,
    output logic                    pulse_req,
    output logic [1:0]              pulse_width,
    input  logic                    pulse_done,
    output logic                    swe_en,
    output logic                    pv_en,
    output logic                    busy,
    output logic                    done,
    output logic                    fail
);
    localparam int               TCW  = 8;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PAGE_BYTES - 1);

    st_e               state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [AT_W-1:0]   att_q;
    logic [PAGE_W-1:0] sel_q;
    logic              miss_q, done_q, fail_q;
    logic [TCW-1:0]    t_cnt;
    logic [AT_W-1:0]   max_eff;
    logic [7:0]        prog_q, rep_q, add_q;
    logic              last, early, mismatch;

    assign max_eff  = (max_attempts == '0) ? AT_W'(DEF_MAX) : max_attempts;
    assign last     = (idx_q == LAST);
    assign early    = (att_q <= AT_W'(Z1_LIMIT));
    assign mismatch = (fl_rdata != prog_q);

    fpv_dwell_timer #(.CW(TCW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .count   (t_cnt)
    );

    fpv_page_buf #(.BYTES(PAGE_BYTES), .IDX_W(IDX_W)) u_buf (
        .clk     (clk),
        .ld_en   (ld_en && (state_q == ST_IDLE)),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .upd_en  (state_q == ST_V_CHECK),
        .upd_idx (idx_q),
        .upd_rep (prog_q | ~fl_rdata),
        .upd_add (prog_q | fl_rdata),
        .rd_idx  (idx_q),
        .prog_q  (prog_q),
        .rep_q   (rep_q),
        .add_q   (add_q)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start) state_d = ST_SWE_ON;
            ST_SWE_ON:     if (t_cnt == TCW'(T_X - 1)) state_d = ST_PROG_WR;
            ST_PROG_WR:    if (last) state_d = ST_PROG_PULSE;
            ST_PROG_PULSE: if (pulse_done) state_d = ST_PV_SET;
            ST_PV_SET:     if (t_cnt == TCW'(T_GAMMA - 1)) state_d = ST_V_DUMMY;
            ST_V_DUMMY:    state_d = ST_V_WAIT;
            ST_V_WAIT:     if (t_cnt == TCW'(T_EPS - 1)) state_d = ST_V_READ;
            ST_V_READ:     state_d = ST_V_CHECK;
            ST_V_CHECK:    state_d = last ? ST_PV_CLR : ST_V_DUMMY;
            ST_PV_CLR:     if (t_cnt == TCW'(T_ETA - 1))
                               state_d = early ? ST_ADD_WR : ST_DECIDE;
            ST_ADD_WR:     if (last) state_d = ST_ADD_PULSE;
            ST_ADD_PULSE:  if (pulse_done) state_d = ST_DECIDE;
            ST_DECIDE:     state_d = (!miss_q || att_q >= max_eff) ? ST_SWE_OFF : ST_PROG_WR;
            ST_SWE_OFF:    if (t_cnt == TCW'(T_THETA - 1)) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            att_q  <= '0;
            sel_q  <= '0;
            miss_q <= 1'b0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    idx_q  <= '0;
                    att_q  <= AT_W'(1);
                    sel_q  <= page_sel;
                    miss_q <= 1'b0;
                    done_q <= 1'b0;
                    fail_q <= 1'b0;
                end
                ST_PROG_WR, ST_ADD_WR: idx_q <= idx_q + 1'b1;
                ST_PROG_PULSE: if (pulse_done) miss_q <= 1'b0;
                ST_V_CHECK: begin
                    idx_q <= idx_q + 1'b1;
                    if (mismatch) miss_q <= 1'b1;
                end
                ST_DECIDE: if (miss_q && att_q < max_eff) att_q <= att_q + 1'b1;
                ST_SWE_OFF: if (t_cnt == TCW'(T_THETA - 1)) begin
                    done_q <= !miss_q;
                    fail_q <= miss_q;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        fl_addr     = {sel_q, idx_q};
        fl_wdata    = 8'hFF;
        fl_we       = 1'b0;
        fl_re       = 1'b0;
        pulse_req   = 1'b0;
        pulse_width = PW_Z1;
        swe_en      = 1'b1;
        pv_en       = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_SWE_OFF: swe_en = 1'b0;
            ST_PROG_WR: begin
                fl_we    = 1'b1;
                fl_wdata = rep_q;
            end
            ST_ADD_WR: begin
                fl_we    = 1'b1;
                fl_wdata = add_q;
            end
            ST_PROG_PULSE: begin
                pulse_req   = 1'b1;
                pulse_width = early ? PW_Z1 : PW_Z2;
            end
            ST_ADD_PULSE: begin
                pulse_req   = 1'b1;
                pulse_width = PW_Z3;
            end
            ST_PV_SET, ST_V_WAIT, ST_V_CHECK: pv_en = 1'b1;
            ST_V_DUMMY: begin
                pv_en = 1'b1;
                fl_we = 1'b1;
            end
            ST_V_READ: begin
                pv_en = 1'b1;
                fl_re = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;
    assign fail = fail_q;
endmodule

// File: rtl/fpv_page_ctrl_chk.sv
module fpv_page_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fl_we,
    input logic       fl_re,
    input logic [7:0] fl_wdata,
    input logic       pulse_req,
    input logic       pulse_done,
    input logic       swe_en,
    input logic       pv_en,
    input logic       busy,
    input logic       done,
    input logic       fail,
    input logic       start
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fl_we && !fl_re && !pulse_req && !swe_en && !pv_en));

    p_we_re_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_req && !pulse_done) |=> pulse_req);

    p_dummy_ff_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we && pv_en) |-> (fl_wdata == 8'hFF));

    p_pulse_no_pv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_req |-> (!pv_en && swe_en));

    p_status_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fail}));

    p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({done, fail}));
endmodule

bind fpv_page_ctrl fpv_page_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fl_we      (fl_we),
    .fl_re      (fl_re),
    .fl_wdata   (fl_wdata),
    .pulse_req  (pulse_req),
    .pulse_done (pulse_done),
    .swe_en     (swe_en),
    .pv_en      (pv_en),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .start      (start)
);

// File: tb/fpv_page_ctrl_tb.sv
`timescale 1ns/1ps
module fpv_page_ctrl_tb;
    localparam int PB = 128;
    localparam int IW = 7;
    localparam int PW = 4;
    localparam int AW = 10;
    localparam int TX = 4;
    localparam int TTH = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [IW-1:0] ld_idx = '0;
    logic [7:0]    ld_data = '0;
    logic          start = 1'b0;
    logic [PW-1:0] page_sel = '0;
    logic [AW-1:0] max_attempts = '0;
    logic [PW+IW-1:0] fl_addr;
    logic [7:0]    fl_wdata;
    logic          fl_we, fl_re;
    logic [7:0]    fl_rdata = 8'hFF;
    logic          pulse_req;
    logic [1:0]    pulse_width;
    logic          pulse_done = 1'b0;
    logic          swe_en, pv_en, busy, done, fail;

    fpv_page_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .start(start), .page_sel(page_sel), .max_attempts(max_attempts),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata), .pulse_req(pulse_req), .pulse_width(pulse_width),
        .pulse_done(pulse_done), .swe_en(swe_en), .pv_en(pv_en), .busy(busy),
        .done(done), .fail(fail)
    );

    // bench state
    logic [7:0] pdat [PB];
    logic [7:0] mem  [PB];
    logic [7:0] latch[PB];
    int hard [PB];
    int pcnt [PB];
    int nprog, nz3, bad_wr, bad_dum, bad_pw, pwc, vwc, lead, lead_got, theta;
    bit after_v, seen_wr, pbusy;
    int pdel;
    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_width();
        if (after_v && nprog <= 6) return 2;
        return (nprog + 1 <= 6) ? 0 : 1;
    endfunction

    // Array and pulse sequencer model, acting between clock edges
    initial begin
        forever begin
            @(negedge clk);
            if (pulse_done) begin
                pulse_done = 1'b0;
                pbusy = 1'b0;
            end else if (pbusy) begin
                if (pdel == 0) begin
                    pulse_done = 1'b1;
                    if (pulse_width == 2'd2) begin
                        for (int i = 0; i < PB; i++) mem[i] = mem[i] & latch[i];
                        nz3++;
                        after_v = 1'b0;
                    end else begin
                        for (int i = 0; i < PB; i++) begin
                            if (latch[i] != 8'hFF) begin
                                pcnt[i]++;
                                if (pcnt[i] >= hard[i]) mem[i] = mem[i] & latch[i];
                            end
                        end
                        nprog++;
                    end
                end else pdel--;
            end else if (pulse_req) begin
                pbusy = 1'b1;
                pdel = 2;
                if (int'(pulse_width) != exp_width()) bad_pw++;
            end
            if (fl_re) begin
                fl_rdata = mem[fl_addr[IW-1:0]];
                if (fl_addr[IW-1:0] == 7'd127) after_v = 1'b1;
            end
            if (fl_we) begin
                automatic int idx = int'(fl_addr[IW-1:0]);
                automatic logic [7:0] expv;
                automatic bit is_add = after_v && nprog <= 6;
                if (fl_addr[PW+IW-1:IW] != page_sel) bad_wr++;
                if (pv_en) begin
                    if (fl_wdata != 8'hFF || idx != vwc % PB) bad_dum++;
                    vwc++;
                end else begin
                    if (!is_add) after_v = 1'b0;
                    if (is_add) expv = (hard[idx] <= nprog) ? pdat[idx] : 8'hFF;
                    else        expv = (nprog >= 1 && hard[idx] <= nprog) ? 8'hFF : pdat[idx];
                    if (idx != pwc % PB || fl_wdata != expv) bad_wr++;
                    pwc++;
                    latch[idx] = fl_wdata;
                    if (!seen_wr) begin
                        seen_wr = 1'b1;
                        lead_got = lead;
                    end
                end
            end
            if (swe_en && !seen_wr) lead++;
            if (busy && !swe_en && seen_wr) theta++;
        end
    end

    task automatic gen(input int maxh, input int ffpct);
        automatic int j = $urandom_range(0, PB - 1);
        for (int i = 0; i < PB; i++) begin
            automatic logic [7:0] r = 8'($urandom);
            if (r == 8'hFF) r = 8'h7F;
            pdat[i] = ($urandom_range(0, 99) < ffpct) ? 8'hFF : r;
            hard[i] = $urandom_range(1, maxh);
        end
        hard[j] = maxh;
        if (pdat[j] == 8'hFF) pdat[j] = 8'h3C;
    endtask

    task automatic load_page();
        for (int i = 0; i < PB; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_idx = IW'(i); ld_data = pdat[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run(input int maxa, input bit disturb, input string tag);
        automatic int needed = 1;
        automatic int lim = (maxa == 0) ? 1000 : maxa;
        automatic int cyc = 0;
        automatic bit ok_exp;
        automatic int att_exp;
        load_page();
        for (int i = 0; i < PB; i++) begin
            mem[i] = 8'hFF; latch[i] = 8'hFF; pcnt[i] = 0;
            if (pdat[i] != 8'hFF && hard[i] > needed) needed = hard[i];
        end
        nprog = 0; nz3 = 0; bad_wr = 0; bad_dum = 0; bad_pw = 0; pwc = 0; vwc = 0;
        lead = 0; lead_got = -1; theta = 0; after_v = 1'b0; seen_wr = 1'b0;
        @(negedge clk);
        page_sel = PW'($urandom); max_attempts = AW'(maxa); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (300) @(negedge clk);
            ld_en = 1'b1; ld_idx = '0; ld_data = pdat[0] ^ 8'h01; start = 1'b1;
            @(negedge clk);
            ld_en = 1'b0; start = 1'b0;
        end
        while (!(done || fail) && cyc < 60000) begin
            @(negedge clk);
            cyc++;
        end
        ok_exp = (needed <= lim);
        att_exp = ok_exp ? needed : lim;
        check(cyc < 60000, {tag, " R10 run ends"}, cyc, 60000);
        check(done == ok_exp && fail == !ok_exp, {tag, ok_exp ? " R10 done" : " R11 fail"},
              int'(done), int'(ok_exp));
        check(nprog == att_exp, {tag, ok_exp ? " R10 attempts" : " R11 attempts"}, nprog, att_exp);
        check(nz3 == ((att_exp < 6) ? att_exp : 6), {tag, " R8 extra pulses"}, nz3,
              (att_exp < 6) ? att_exp : 6);
        check(bad_wr == 0, {tag, " R4 R7 write order/data"}, bad_wr, 0);
        check(bad_dum == 0 && vwc == PB * att_exp, {tag, " R6 dummy writes"}, vwc, PB * att_exp);
        check(bad_pw == 0, {tag, " R5 pulse widths"}, bad_pw, 0);
        check(lead_got == TX, {tag, " R3 enable lead"}, lead_got, TX);
        check(theta == TTH, {tag, " R3 exit settle"}, theta, TTH);
        if (disturb) check(done == ok_exp, {tag, " R2 R12 busy load/start ignored"}, int'(done), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !fail && !swe_en && !pv_en && !fl_we && !fl_re && !pulse_req,
              "R1 reset idle", int'(busy), 0);

        gen(1, 20);  run(5, 1'b0, "single");
        gen(8, 10);  run(20, 1'b1, "long+disturb");
        gen(5, 0);   run(3, 1'b0, "limit");
        for (int i = 0; i < PB; i++) begin pdat[i] = 8'hFF; hard[i] = 1; end
        run(1, 1'b0, "erased");
        gen(9, 10);  run(0, 1'b0, "R11 zero-limit");
        gen(6, 0);   run(6, 1'b0, "at-limit");
        gen(7, 0);   run(6, 1'b0, "past-limit");
        for (int k = 0; k < 3; k++) begin
            gen($urandom_range(1, 10), $urandom_range(0, 30));
            run($urandom_range(1, 12), 1'b0, "random");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule